// File: doc/BRIEF.md
# ASID-Tagged Set-Associative Translation Buffer

This block translates a 32-bit virtual address for a load, a store or an instruction fetch. Its entries are spread over four ways and four sets; the set is chosen by the two virtual page bits just above the 4 KiB page offset. Every entry carries a virtual page number, a physical page number, an 8-bit address-space tag and a 4-bit attribute. An entry only counts as a hit when its tag is nonzero and appears as one of the four bytes of a ring-map register. The position of that byte gives the entry's privilege ring.

Each lookup produces one registered response one cycle later. The response holds the physical address, a read/write/execute permission mask and a cause code. When there is no hit, the address of the page-table entry for the faulting page is already on an output, ready for an external walker. That walker later returns the page-table entry through the refill port. The refill goes into the next way of a round-robin sequence, and its ring comes from the page-table entry.

Top module: `xlat_buffer`

## Requirements
- R1: While reset is low, `rsp_valid` is 0. After reset the ring-map register holds 0x04030201, every entry has tag 0 (so every lookup misses), and the round-robin counter is 0.
- R2: An entry qualifies only when three conditions all hold: its page number equals `lk_vaddr[31:12]`, its tag is nonzero, and its tag equals some byte of the ring-map register. An entry whose tag is absent from the register is ignored.
- R3: The ring of a qualifying entry is the index (0..3) of the lowest ring-map byte that equals its tag. Byte k is bits [8k+7:8k].
- R4: Two or more qualifying entries give cause 3 for a fetch (kind 2) or cause 4 for a load (kind 0) or store (kind 1). In that case `rsp_perm` is 0.
- R5: Zero qualifying entries give cause 1 for a fetch or cause 2 for data, with `rsp_perm` 0.
- R6: For a single hit whose ring is numerically below `lk_priv`, the cause is 5 for a fetch or 6 for data.
- R7: For a single hit, `rsp_perm` decodes the attribute as follows, with bit0=read, bit1=write, bit2=execute. Values 0..11 grant read. Within that range, attribute bit 0 adds execute and attribute bit 1 adds write. Value 13 grants read and write. Every other value grants nothing.
- R8: For a single hit that passes the ring check but lacks the needed right, the cause is 7 for a fetch without execute, 8 for a load without read, or 9 for a store without write. Otherwise the cause is 0.
- R9: On cause 0, `rsp_paddr` is the entry's physical page number followed by `lk_vaddr[11:0]`.
- R10: `rsp_pte_addr` equals (`pt_base` OR (`lk_vaddr` >> 10)) with bits [1:0] cleared, for every response.
- R11: The refill port does two things on each write. First it pre-increments a 2-bit counter and writes way (counter+1) mod 4 in set `rf_vaddr[13:12]`. Second it fills the entry: physical page from `rf_pte[31:12]`, attribute from `rf_pte[3:0]`, and tag from the ring-map byte selected by `rf_pte[5:4]`.
- R12: `rsp_valid` follows `lk_valid` by one cycle. A lookup sees the table and ring map as they stood before any refill or ring-map write in the same cycle; that write is seen from the next lookup on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | 0 load, 1 store, 2 fetch |
| lk_priv | input | 2 | Current privilege index of the access |
| pt_base | input | 32 | Page-table base used for the entry address |
| rf_valid | input | 1 | Refill write strobe |
| rf_vaddr | input | 32 | Virtual address being refilled |
| rf_pte | input | 32 | Page-table entry from the walker |
| rmap_we | input | 1 | Ring-map register write strobe |
| rmap_wdata | input | 32 | New ring-map value |
| rsp_valid | output | 1 | Response present |
| rsp_cause | output | 4 | 0 on success, else fault cause |
| rsp_perm | output | 3 | Permission mask {exec, write, read} |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_pte_addr | output | 32 | Page-table entry address for this lookup |

## Verification
The lookup path is exercised with single hits of several attribute values under load, store and fetch. This separates the read/write/execute decode from the cause selection, and a change in one shows up apart from the other. Duplicate refills of one page are used to raise the multi-hit path. Five refills into one set show which way the round robin evicts. Rewrites of the ring map make an existing entry disappear or change ring, which shows that qualification and ring both come from the register and not from the entry alone. A lookup issued in the same cycle as its own refill shows the old-table view. The next lookup then shows the new entry.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W   = 32;
  localparam int PAGE_W = 12;
  localparam int VPN_W  = VA_W - PAGE_W;
  localparam int TAG_W  = 8;
  localparam int ATTR_W = 4;
  localparam logic [31:0] RMAP_RESET = 32'h0403_0201;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2
  } kind_e;

  typedef enum logic [3:0] {
    C_OK         = 4'd0,
    C_MISS_I     = 4'd1,
    C_MISS_D     = 4'd2,
    C_MULTI_I    = 4'd3,
    C_MULTI_D    = 4'd4,
    C_PRIV_I     = 4'd5,
    C_PRIV_D     = 4'd6,
    C_NOFETCH    = 4'd7,
    C_NOLOAD     = 4'd8,
    C_NOSTORE    = 4'd9
  } cause_e;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  ppn;
    logic [TAG_W-1:0]  tag;
    logic [ATTR_W-1:0] attr;
  } xlat_entry_t;

  // perm bit0 read, bit1 write, bit2 execute
  function automatic logic [2:0] attr_rights(input logic [ATTR_W-1:0] a);
    logic [2:0] p;
    p = 3'b000;
    if (a < 4'd12) begin
      p[0] = 1'b1;
      p[2] = a[0];
      p[1] = a[1];
    end else if (a == 4'd13) begin
      p = 3'b011;
    end
    return p;
  endfunction
endpackage

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int NWAYS = 4,
  parameter int NSETS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [$clog2(NSETS)-1:0] rd_idx,
  output xlat_entry_t            rd_ents [NWAYS],
  input  logic                   wr_en,
  input  logic [VA_W-1:0]        wr_vaddr,
  input  logic [31:0]            wr_pte,
  input  logic [31:0]            ring_map
);
  localparam int IDX_W = $clog2(NSETS);
  localparam int PTR_W = $clog2(NWAYS);

  logic [PTR_W-1:0] ptr_q, ptr_d, wr_way;
  logic [IDX_W-1:0] wr_idx;
  xlat_entry_t      wr_ent;
  xlat_entry_t      mem_q [NWAYS][NSETS];

  always_comb begin
    wr_way      = ptr_q + 1'b1;
    ptr_d       = wr_en ? wr_way : ptr_q;
    wr_idx      = wr_vaddr[PAGE_W +: IDX_W];
    wr_ent.vpn  = wr_vaddr[VA_W-1:PAGE_W];
    wr_ent.ppn  = wr_pte[31:PAGE_W];
    wr_ent.attr = wr_pte[ATTR_W-1:0];
    wr_ent.tag  = ring_map[8*wr_pte[5:4] +: TAG_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    for (genvar s = 0; s < NSETS; s++) begin : g_set
      localparam logic [PTR_W-1:0] WAY_ID = PTR_W'(w);
      localparam logic [IDX_W-1:0] SET_ID = IDX_W'(s);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q[w][s] <= '0;
        else if (wr_en && wr_way == WAY_ID && wr_idx == SET_ID) mem_q[w][s] <= wr_ent;
      end
    end
    assign rd_ents[w] = mem_q[w][rd_idx];
  end

  assert_refill_advance_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr_q == $past(ptr_q) + 1'b1);
  assert_counter_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ptr_q));
endmodule

// File: rtl/xlat_match.sv
module xlat_match
  import xlat_pkg::*;
#(
  parameter int NWAYS = 4
) (
  input  xlat_entry_t               ents [NWAYS],
  input  logic [VPN_W-1:0]          vpn,
  input  logic [31:0]               ring_map,
  output logic [$clog2(NWAYS+1)-1:0] nhit,
  output xlat_entry_t               sel_ent,
  output logic [1:0]                sel_ring
);
  localparam int CNT_W = $clog2(NWAYS + 1);

  logic [NWAYS-1:0] qual;
  logic [1:0]       ring_w [NWAYS];

  for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
    always_comb begin
      logic found;
      found     = 1'b0;
      ring_w[w] = 2'd0;
      for (int b = 3; b >= 0; b--) begin
        if (ring_map[8*b +: TAG_W] == ents[w].tag) begin
          found     = 1'b1;
          ring_w[w] = 2'(b);
        end
      end
      qual[w] = found && (ents[w].tag != '0) && (ents[w].vpn == vpn);
    end
  end

  always_comb begin
    nhit     = '0;
    sel_ent  = ents[0];
    sel_ring = ring_w[0];
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (qual[w]) begin
        nhit     = nhit + CNT_W'(1);
        sel_ent  = ents[w];
        sel_ring = ring_w[w];
      end
    end
  end
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int NWAYS = 4,
  parameter int NSETS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lk_valid,
  input  logic [31:0] lk_vaddr,
  input  logic [1:0]  lk_kind,
  input  logic [1:0]  lk_priv,
  input  logic [31:0] pt_base,
  input  logic        rf_valid,
  input  logic [31:0] rf_vaddr,
  input  logic [31:0] rf_pte,
  input  logic        rmap_we,
  input  logic [31:0] rmap_wdata,
  output logic        rsp_valid,
  output logic [3:0]  rsp_cause,
  output logic [2:0]  rsp_perm,
  output logic [31:0] rsp_paddr,
  output logic [31:0] rsp_pte_addr
);
  localparam int IDX_W = $clog2(NSETS);
  localparam int CNT_W = $clog2(NWAYS + 1);

  logic [31:0]       rmap_q, rmap_d;
  xlat_entry_t       ents [NWAYS];
  xlat_entry_t       sel_ent;
  logic [1:0]        sel_ring;
  logic [CNT_W-1:0]  nhit;
  logic              is_fetch, granted;
  logic [2:0]        rights;
  cause_e            cause_d;
  logic [2:0]        perm_d;
  logic [31:0]       paddr_d, pte_d;

  xlat_store #(.NWAYS(NWAYS), .NSETS(NSETS)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (lk_vaddr[PAGE_W +: IDX_W]),
    .rd_ents  (ents),
    .wr_en    (rf_valid),
    .wr_vaddr (rf_vaddr),
    .wr_pte   (rf_pte),
    .ring_map (rmap_q)
  );

  xlat_match #(.NWAYS(NWAYS)) u_match (
    .ents     (ents),
    .vpn      (lk_vaddr[VA_W-1:PAGE_W]),
    .ring_map (rmap_q),
    .nhit     (nhit),
    .sel_ent  (sel_ent),
    .sel_ring (sel_ring)
  );

  always_comb begin
    rmap_d   = rmap_we ? rmap_wdata : rmap_q;
    is_fetch = (lk_kind == KIND_FETCH);
    rights   = attr_rights(sel_ent.attr);
    case (lk_kind)
      KIND_STORE: granted = rights[1];
      KIND_FETCH: granted = rights[2];
      default:    granted = rights[0];
    endcase
    perm_d  = 3'b000;
    paddr_d = {sel_ent.ppn, lk_vaddr[PAGE_W-1:0]};
    pte_d   = (pt_base | (lk_vaddr >> 10)) & 32'hFFFF_FFFC;
    cause_d = C_OK;
    if (nhit == '0) begin
      cause_d = is_fetch ? C_MISS_I : C_MISS_D;
    end else if (nhit > CNT_W'(1)) begin
      cause_d = is_fetch ? C_MULTI_I : C_MULTI_D;
    end else begin
      perm_d = rights;
      if (sel_ring < lk_priv)   cause_d = is_fetch ? C_PRIV_I : C_PRIV_D;
      else if (!granted) begin
        case (lk_kind)
          KIND_STORE: cause_d = C_NOSTORE;
          KIND_FETCH: cause_d = C_NOFETCH;
          default:    cause_d = C_NOLOAD;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rmap_q       <= RMAP_RESET;
      rsp_valid    <= 1'b0;
      rsp_cause    <= '0;
      rsp_perm     <= '0;
      rsp_paddr    <= '0;
      rsp_pte_addr <= '0;
    end else begin
      rmap_q    <= rmap_d;
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_cause    <= cause_d;
        rsp_perm     <= perm_d;
        rsp_paddr    <= paddr_d;
        rsp_pte_addr <= pte_d;
      end
    end
  end

  assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  assert_idle_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  assert_success_has_right_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause == 4'd0) |-> rsp_perm != 3'b000);
  assert_nohit_noperm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause >= 4'd1 && rsp_cause <= 4'd4) |-> rsp_perm == 3'b000);
  assert_pte_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_pte_addr[1:0] == 2'b00);
  assert_cause_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_cause <= 4'd9);
endmodule

// File: tb/xlat_buffer_test.sv
module xlat_buffer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [1:0]  lk_kind = '0;
  logic [1:0]  lk_priv = '0;
  logic [31:0] pt_base = 32'h8000_0000;
  logic        rf_valid = 1'b0;
  logic [31:0] rf_vaddr = '0;
  logic [31:0] rf_pte = '0;
  logic        rmap_we = 1'b0;
  logic [31:0] rmap_wdata = '0;
  logic        rsp_valid;
  logic [3:0]  rsp_cause;
  logic [2:0]  rsp_perm;
  logic [31:0] rsp_paddr;
  logic [31:0] rsp_pte_addr;

  xlat_buffer uut (.*);

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;

  // behavioural reference state
  int unsigned m_vpn [4][4];
  int unsigned m_ppn [4][4];
  int unsigned m_tag [4][4];
  int unsigned m_attr[4][4];
  int unsigned m_cnt;
  int unsigned m_rmap;

  bit          e_valid;
  int unsigned e_cause, e_perm, e_paddr, e_pte;
  string       e_tag;

  task automatic check(input bit ok, input string tag, input string what,
                       input int unsigned act, input int unsigned exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int unsigned rights(input int unsigned a);
    int unsigned p = 0;
    if (a < 12) begin
      p = 1;
      if (a % 2 == 1) p += 4;
      if ((a / 2) % 2 == 1) p += 2;
    end else if (a == 13) p = 3;
    return p;
  endfunction

  task automatic model_lookup(input int unsigned va, input int kind, input int priv);
    int nh = 0, hw = 0, hr = 0;
    int s = (va >> 12) % 4;
    bit fetch = (kind == 2);
    for (int w = 0; w < 4; w++) begin
      int ring = -1;
      if (m_vpn[w][s] == (va >> 12) && m_tag[w][s] != 0) begin
        for (int b = 0; b < 4; b++)
          if (ring < 0 && ((m_rmap >> (8*b)) & 255) == m_tag[w][s]) ring = b;
        if (ring >= 0) begin nh++; hw = w; hr = ring; end
      end
    end
    e_perm  = 0;
    e_paddr = 0;
    e_pte   = (pt_base | (va >> 10)) & 32'hFFFF_FFFC;
    if (nh == 0)      e_cause = fetch ? 1 : 2;
    else if (nh > 1)  e_cause = fetch ? 3 : 4;
    else begin
      int unsigned need;
      e_perm  = rights(m_attr[hw][s]);
      e_paddr = (m_ppn[hw][s] << 12) | (va & 32'hFFF);
      need    = (kind == 1) ? 2 : (kind == 2) ? 4 : 1;
      if (hr < priv)                 e_cause = fetch ? 5 : 6;
      else if ((e_perm & need) == 0) e_cause = (kind == 1) ? 9 : (kind == 2) ? 7 : 8;
      else                           e_cause = 0;
    end
  endtask

  task automatic model_refill(input int unsigned va, input int unsigned pte);
    int s = (va >> 12) % 4;
    m_cnt = (m_cnt + 1) % 4;
    m_vpn [m_cnt][s] = va >> 12;
    m_ppn [m_cnt][s] = pte >> 12;
    m_attr[m_cnt][s] = pte & 15;
    m_tag [m_cnt][s] = (m_rmap >> (8 * ((pte >> 4) & 3))) & 255;
  endtask

  // one clock: drive at negedge, predict, compare one cycle later
  task automatic step(input bit lv, input int unsigned va, input int kind, input int priv,
                      input bit rv, input int unsigned rva, input int unsigned rpte,
                      input bit wv, input int unsigned wdat, input string tag);
    lk_valid = lv; lk_vaddr = va; lk_kind = 2'(kind); lk_priv = 2'(priv);
    rf_valid = rv; rf_vaddr = rva; rf_pte = rpte;
    rmap_we = wv; rmap_wdata = wdat;
    e_valid = lv;
    e_tag   = tag;
    if (lv) model_lookup(va, kind, priv);
    if (rv) model_refill(rva, rpte);
    if (wv) m_rmap = wdat;
    @(negedge clk);
    check(rsp_valid == e_valid, e_tag, "valid", rsp_valid, e_valid);
    if (e_valid) begin
      check(rsp_cause == e_cause, e_tag, "cause", rsp_cause, e_cause);
      check(rsp_perm == e_perm, e_tag, "perm", rsp_perm, e_perm);
      check(rsp_pte_addr == e_pte, e_tag, "pte_addr", rsp_pte_addr, e_pte);
      if (e_cause == 0) check(rsp_paddr == e_paddr, e_tag, "paddr", rsp_paddr, e_paddr);
    end
  endtask

  task automatic look(input int unsigned va, input int kind, input int priv, input string tag);
    step(1, va, kind, priv, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic fill(input int unsigned va, input int unsigned pte, input string tag);
    step(0, 0, 0, 0, 1, va, pte, 0, 0, tag);
  endtask
  task automatic rmap(input int unsigned v, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 1, v, tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nfail++;
      $display("FAIL R12 watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 4; s++) begin
        m_vpn[w][s] = 0; m_ppn[w][s] = 0; m_tag[w][s] = 0; m_attr[w][s] = 0;
      end
    m_cnt  = 0;
    m_rmap = 32'h0403_0201;
    lk_valid = 1'b1;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1", "valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    lk_valid = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1", "valid after reset", rsp_valid, 0);

    // empty table misses, entry address presented (R1 R5 R10)
    look(32'h0000_1234, 0, 0, "R5");
    look(32'h7654_3ABC, 2, 0, "R10");
    // first refill lands in way 1 (R11), ring 0, attr 3
    fill(32'h0000_1000, 32'h1234_5003, "R11");
    look(32'h0000_1ABC, 0, 0, "R9");
    look(32'h0000_1ABC, 1, 3, "R7");
    look(32'h0000_1ABC, 2, 0, "R7");
    // ring 1, attr 0: read only
    fill(32'h0000_2000, 32'hABCD_E010, "R11");
    look(32'h0000_2004, 1, 0, "R8");
    look(32'h0000_2004, 2, 0, "R8");
    look(32'h0000_2004, 0, 1, "R6");
    look(32'h0000_2004, 0, 2, "R6");
    look(32'h0000_2004, 2, 3, "R6");
    // attributes 13, 14, 6, 12
    fill(32'h0000_3000, 32'h0000_300D, "R7");
    look(32'h0000_3FFF, 0, 0, "R7");
    look(32'h0000_3FFF, 2, 0, "R8");
    fill(32'h0000_4000, 32'h0000_400E, "R7");
    look(32'h0000_4010, 0, 0, "R8");
    fill(32'h0001_0000, 32'h0005_5026, "R7");
    look(32'h0001_0800, 1, 2, "R7");
    look(32'h0001_0800, 2, 0, "R8");
    fill(32'h0002_1000, 32'h0006_600C, "R7");
    look(32'h0002_1000, 0, 0, "R8");
    // duplicate page gives multi-hit
    fill(32'h0000_1000, 32'h2222_2003, "R4");
    look(32'h0000_1000, 0, 0, "R4");
    look(32'h0000_1000, 2, 0, "R4");
    // round robin over set 3: five fills, first evicted
    for (int i = 0; i < 5; i++)
      fill(32'h1000_3000 + i * 32'h0001_0000, 32'h0100_0003 + i * 32'h1000, "R11");
    look(32'h1000_3000, 0, 0, "R11");
    look(32'h1001_3000, 0, 0, "R11");
    look(32'h1004_3123, 0, 0, "R11");
    // ring map: tag 1 removed, then moved to byte 3
    rmap(32'h0403_0205, "R2");
    look(32'h1004_3123, 0, 0, "R2");
    rmap(32'h0103_0205, "R3");
    look(32'h1004_3123, 0, 3, "R3");
    look(32'h0000_2004, 0, 2, "R3");
    // ring byte of zero yields an unusable entry
    rmap(32'h0403_0200, "R2");
    fill(32'h0003_2000, 32'h0777_7003, "R2");
    look(32'h0003_2000, 0, 0, "R2");
    rmap(32'h0403_0201, "R2");
    // lookup concurrent with its own refill sees the old table
    step(1, 32'h0004_0000, 0, 0, 1, 32'h0004_0000, 32'h0888_8003, 0, 0, "R12");
    look(32'h0004_0000, 0, 0, "R12");
    // ring-map write concurrent with lookup
    step(1, 32'h0004_0000, 0, 0, 0, 0, 0, 1, 32'h0403_0209, "R12");
    look(32'h0004_0000, 0, 0, "R12");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule